// File: doc/BRIEF.md
# Pixel Byte FIFO with Format-Dependent Back-Pressure Level

This block sits between a pixel compositor and the active-video consumer of a display timing generator, on a single clock. The compositor pushes one pixel per accepted write, and the consumer pops one pixel per read request. Capacity is counted in bytes: every stored pixel takes two or three byte slots, depending on the output pixel format in force when it was written. The physical store holds 64 bytes.

The `full` output is a back-pressure hint and is not a hard stop. It rises at a level kept below the physical capacity, so the pixels the compositor already has in flight still fit. By default that level is the capacity minus the bytes the upstream latency (six pixels) needs at the current format. A custom level can replace it. Writes are still accepted above the level until the physical byte capacity would be exceeded.

A synchronous clear flushes the store. An optional mode flushes it at every frame-start pulse. When the underflow trigger is enabled, a read request against an empty store sets a sticky error flag. The read data output then keeps showing the last pixel that was delivered.

Top module: `pixel_fifo_thr`

## Requirements
- R1: The `fmt` code sets the byte slots taken by a written pixel. Code 0 is 16-bit and takes 2 slots. Code 1 is 18-bit and takes 3 slots. Codes 2 and 3 are 24-bit and take 3 slots. `occ_bytes` is the sum of the slots of all held pixels.
- R2: With the custom level off, the level is 64 minus ceil(6 × bits / 8), which gives 52, 50 and 46 for 16, 18 and 24 bits. `full` is high exactly when `occ_bytes` is greater than or equal to the level.
- R3: With `thr_custom_en` high, `thr_custom` replaces the default level in the R2 comparison.
- R4: A write is accepted only when `occ_bytes` plus the slots of the current format is 64 or less. `wr_ready` shows that condition. A refused write leaves `occ_bytes` and the stored contents unchanged.
- R5: Pixels leave in write order. `rd_data` shows the popped pixel one cycle after a read of a non-empty store. Each pixel frees the slots it was written with, even if `fmt` has changed since.
- R6: A `clr` pulse empties the store by the next cycle, even if a write or read arrives in the same cycle. It also clears the underflow flag.
- R7: When `sof_clr_en` is high, a `sof` pulse empties the store and leaves the underflow flag as it is. When `sof_clr_en` is low, `sof` has no effect.
- R8: A read of an empty store leaves `rd_data` at the last delivered pixel. When `uflow_trig_en` is high, it also sets `uflow`, which stays high until `clr`. When `uflow_trig_en` is low, `uflow` is not set.
- R9: After reset, `occ_bytes`, `full`, `uflow` and `rd_data` are all zero, and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Output pixel format code |
| thr_custom_en | input | 1 | Use the custom level instead of the default |
| thr_custom | input | 7 | Custom back-pressure level in bytes |
| clr | input | 1 | Synchronous flush that also clears the underflow flag |
| sof_clr_en | input | 1 | Flush on every frame-start pulse |
| sof | input | 1 | Frame-start pulse |
| uflow_trig_en | input | 1 | Enable the underflow flag |
| wr_en | input | 1 | Write request from the compositor |
| wr_data | input | 24 | Pixel to write |
| wr_ready | output | 1 | A write would be accepted this cycle |
| full | output | 1 | Back-pressure: occupancy has reached the level |
| rd_en | input | 1 | Read request from the consumer |
| rd_data | output | 24 | Last popped pixel |
| occ_bytes | output | 7 | Occupancy in byte slots |
| uflow | output | 1 | Sticky underflow flag |

## Verification
The assertions check five properties on every cycle:
- occupancy never goes past the byte capacity;
- `full` follows an independently computed level;
- a flush empties the store;
- a read of an empty store holds `rd_data`;
- a refused write leaves the occupancy unchanged.

Other behaviour can only be shown by the bench's scenarios:
- pixels come out in write order with the right values;
- the exact number of pixels that fit at each format;
- slots are released correctly after a format change in the middle of a stream;
- the underflow flag survives a frame-start flush.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   typedef enum logic [1:0] {
      PF_RGB16 = 2'd0,
      PF_RGB18 = 2'd1,
      PF_RGB24 = 2'd2,
      PF_DEFLT = 2'd3
   } pix_fmt_e;

   function automatic int unsigned fmt_bits(input pix_fmt_e f);
      case (f)
         PF_RGB16: return 16;
         PF_RGB18: return 18;
         default:  return 24;
      endcase
   endfunction

   // byte slots a stored pixel occupies
   function automatic int unsigned fmt_slots(input pix_fmt_e f);
      return (f == PF_RGB16) ? 2 : 3;
   endfunction

   // bytes reserved for the upstream pixels still in flight
   function automatic int unsigned fmt_margin(input pix_fmt_e f, input int unsigned lat);
      return (lat * fmt_bits(f) + 7) / 8;
   endfunction

endpackage

// File: rtl/pfx_level.sv
module pfx_level
   import pfx_pkg::*;
#(
   parameter int unsigned DEPTH_BYTES  = 64,
   parameter int unsigned LAT_PIX      = 6,
   parameter bit          ALLOW_CUSTOM = 1'b1,
   localparam int unsigned OCC_W       = $clog2(DEPTH_BYTES + 1)
) (
   input  pix_fmt_e         fmt,
   input  logic             cust_en,
   input  logic [OCC_W-1:0] cust_lvl,
   output logic [OCC_W-1:0] level,
   output logic [1:0]       slots
);
   logic [OCC_W-1:0] dflt_lvl;

   always_comb begin
      dflt_lvl = OCC_W'(DEPTH_BYTES - fmt_margin(fmt, LAT_PIX));
      slots    = 2'(fmt_slots(fmt));
   end

   generate
      if (ALLOW_CUSTOM) begin : g_custom
         assign level = cust_en ? cust_lvl : dflt_lvl;
      end else begin : g_fixed
         logic unused_cust;
         assign unused_cust = cust_en ^ (^cust_lvl);
         assign level = dflt_lvl;
      end
   endgenerate

endmodule

// File: rtl/pfx_store.sv
module pfx_store #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned PIX_W   = 24,
   localparam int unsigned PTR_W  = $clog2(ENTRIES),
   localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [PIX_W-1:0] push_data,
   input  logic [1:0]       push_sz,
   input  logic             pop,
   output logic [PIX_W-1:0] head_data,
   output logic [1:0]       head_sz,
   output logic [CNT_W-1:0] count
);
   logic [PIX_W-1:0] mem_d [ENTRIES];
   logic [1:0]       mem_s [ENTRIES];
   logic [PTR_W-1:0] wptr, rptr;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) begin
         mem_d[wptr] <= push_data;
         mem_s[wptr] <= push_sz;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= bump(wptr);
         if (pop)  rptr <= bump(rptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_data = mem_d[rptr];
   assign head_sz   = mem_s[rptr];

endmodule

// File: rtl/pixel_fifo_thr.sv
module pixel_fifo_thr
   import pfx_pkg::*;
#(
   parameter int unsigned DEPTH_BYTES  = 64,
   parameter int unsigned LAT_PIX      = 6,
   parameter int unsigned PIX_W        = 24,
   parameter bit          ALLOW_CUSTOM = 1'b1,
   localparam int unsigned OCC_W       = $clog2(DEPTH_BYTES + 1),
   localparam int unsigned ENTRIES     = DEPTH_BYTES / 2,
   localparam int unsigned CNT_W       = $clog2(ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       fmt,
   input  logic             thr_custom_en,
   input  logic [OCC_W-1:0] thr_custom,
   input  logic             clr,
   input  logic             sof_clr_en,
   input  logic             sof,
   input  logic             uflow_trig_en,
   input  logic             wr_en,
   input  logic [PIX_W-1:0] wr_data,
   output logic             wr_ready,
   output logic             full,
   input  logic             rd_en,
   output logic [PIX_W-1:0] rd_data,
   output logic [OCC_W-1:0] occ_bytes,
   output logic             uflow
);
   generate
      if (DEPTH_BYTES < 4 || (DEPTH_BYTES % 2) != 0) begin : g_bad_depth
         $error("DEPTH_BYTES must be even and at least 4");
      end
      if (PIX_W < 16) begin : g_bad_width
         $error("PIX_W must hold a 16-bit pixel");
      end
      if ((LAT_PIX * 3) >= DEPTH_BYTES) begin : g_bad_lat
         $error("latency margin exceeds the byte capacity");
      end
   endgenerate

   logic [OCC_W-1:0] level;
   logic [1:0]       slots, head_sz;
   logic [PIX_W-1:0] head_data;
   logic [CNT_W-1:0] count;
   logic             flush, empty, push, pop;
   logic [OCC_W:0]   occ_after_wr;

   pfx_level #(
      .DEPTH_BYTES (DEPTH_BYTES),
      .LAT_PIX     (LAT_PIX),
      .ALLOW_CUSTOM(ALLOW_CUSTOM)
   ) u_level (
      .fmt     (pix_fmt_e'(fmt)),
      .cust_en (thr_custom_en),
      .cust_lvl(thr_custom),
      .level   (level),
      .slots   (slots)
   );

   pfx_store #(
      .ENTRIES(ENTRIES),
      .PIX_W  (PIX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push     (push),
      .push_data(wr_data),
      .push_sz  (slots),
      .pop      (pop),
      .head_data(head_data),
      .head_sz  (head_sz),
      .count    (count)
   );

   always_comb begin
      flush        = clr | (sof_clr_en & sof);
      empty        = (count == '0);
      occ_after_wr = {1'b0, occ_bytes} + (OCC_W + 1)'(slots);
      wr_ready     = (occ_after_wr <= (OCC_W + 1)'(DEPTH_BYTES));
      push         = wr_en & wr_ready & ~flush;
      pop          = rd_en & ~empty & ~flush;
      full         = (occ_bytes >= level);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         occ_bytes <= '0;
      end else begin
         occ_bytes <= occ_bytes + (push ? OCC_W'(slots) : '0) - (pop ? OCC_W'(head_sz) : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (pop) begin
         rd_data <= head_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         uflow <= 1'b0;
      end else if (rd_en && empty && uflow_trig_en) begin
         uflow <= 1'b1;
      end
   end

endmodule

// File: rtl/pfx_chk.sv
module pfx_chk #(
   parameter int unsigned DEPTH_BYTES  = 64,
   parameter int unsigned LAT_PIX      = 6,
   parameter int unsigned PIX_W        = 24,
   parameter bit          ALLOW_CUSTOM = 1'b1,
   localparam int unsigned OCC_W       = $clog2(DEPTH_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       fmt,
   input logic             thr_custom_en,
   input logic [OCC_W-1:0] thr_custom,
   input logic             clr,
   input logic             sof_clr_en,
   input logic             sof,
   input logic             uflow_trig_en,
   input logic             wr_en,
   input logic [PIX_W-1:0] wr_data,
   input logic             wr_ready,
   input logic             full,
   input logic             rd_en,
   input logic [PIX_W-1:0] rd_data,
   input logic [OCC_W-1:0] occ_bytes,
   input logic             uflow
);
   int unsigned exp_lvl;
   always_comb begin
      case (fmt)
         2'd0:    exp_lvl = DEPTH_BYTES - (LAT_PIX * 2);
         2'd1:    exp_lvl = DEPTH_BYTES - ((LAT_PIX * 9 + 3) / 4);
         default: exp_lvl = DEPTH_BYTES - (LAT_PIX * 3);
      endcase
      if (ALLOW_CUSTOM && thr_custom_en) exp_lvl = thr_custom;
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ_bytes <= OCC_W'(DEPTH_BYTES));

   a_r2_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      full == (int'(occ_bytes) >= exp_lvl));

   a_r6_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (occ_bytes == '0) && !uflow);

   a_r7_sof_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && sof_clr_en) |=> occ_bytes == '0);

   a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && occ_bytes == '0) |=> $stable(rd_data));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !clr) |=> uflow);

   a_r4_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ready && !rd_en && !clr && !(sof && sof_clr_en)) |=> $stable(occ_bytes));

endmodule

bind pixel_fifo_thr pfx_chk #(
   .DEPTH_BYTES (DEPTH_BYTES),
   .LAT_PIX     (LAT_PIX),
   .PIX_W       (PIX_W),
   .ALLOW_CUSTOM(ALLOW_CUSTOM)
) u_chk (.*);

// File: tb/sim_pixel_fifo_thr.sv
module sim_pixel_fifo_thr;
   localparam int CLK_PERIOD = 10;
   localparam int CAP = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  fmt;
   logic        thr_custom_en;
   logic [6:0]  thr_custom;
   logic        clr, sof_clr_en, sof, uflow_trig_en, wr_en, rd_en;
   logic [23:0] wr_data;
   logic        wr_ready, full, uflow;
   logic [23:0] rd_data;
   logic [6:0]  occ_bytes;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pixel_fifo_thr u0 (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .thr_custom_en(thr_custom_en),
      .thr_custom(thr_custom), .clr(clr), .sof_clr_en(sof_clr_en), .sof(sof),
      .uflow_trig_en(uflow_trig_en), .wr_en(wr_en), .wr_data(wr_data),
      .wr_ready(wr_ready), .full(full), .rd_en(rd_en), .rd_data(rd_data),
      .occ_bytes(occ_bytes), .uflow(uflow)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   function automatic int slots_of(input int f);
      return (f == 0) ? 2 : 3;
   endfunction

   function automatic int dflt_lvl(input int f);
      int bits;
      bits = (f == 0) ? 16 : (f == 1) ? 18 : 24;
      return CAP - (6 * bits + 7) / 8;
   endfunction

   task automatic flush_now();
      clr = 1'b1; cyc(); clr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; fmt = 2'd0; thr_custom_en = 1'b0; thr_custom = 7'd20;
      clr = 1'b0; sof_clr_en = 1'b0; sof = 1'b0; uflow_trig_en = 1'b0;
      wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R9 reset state
      chk(occ_bytes == 0, "R9 occ", occ_bytes, 0);
      chk(full == 0, "R9 full", full, 0);
      chk(uflow == 0, "R9 uflow", uflow, 0);
      chk(rd_data == 0, "R9 rd_data", rd_data, 0);
      chk(wr_ready == 1, "R9 wr_ready", wr_ready, 1);

      // sweep: every format, default and custom level
      for (int f = 0; f < 4; f++) begin
         for (int c = 0; c < 2; c++) begin
            int sl, lvl, n, base;
            sl = slots_of(f);
            lvl = c ? 20 : dflt_lvl(f);
            base = f * 4096 + c * 256;
            fmt = 2'(f); thr_custom_en = 1'(c); uflow_trig_en = 1'(c);
            flush_now();
            n = 0;
            while (wr_ready && n < 40) begin
               chk(occ_bytes == 7'(n * sl), "R1 occupancy", occ_bytes, n * sl);
               chk(full == (n * sl >= lvl), c ? "R3 custom full" : "R2 default full",
                   full, (n * sl >= lvl));
               wr_en = 1'b1; wr_data = 24'(base + n);
               cyc();
               n++;
            end
            wr_en = 1'b0;
            chk(n == CAP / sl, "R4 pixels accepted", n, CAP / sl);
            chk(full == (n * sl >= lvl), "R2 full at cap", full, 1);
            wr_en = 1'b1; wr_data = 24'hFFFFFF; cyc(); wr_en = 1'b0;
            chk(occ_bytes == 7'(n * sl), "R4 refused write", occ_bytes, n * sl);
            for (int i = 0; i < n; i++) begin
               rd_en = 1'b1; cyc();
               chk(rd_data == 24'(base + i), "R5 order", rd_data, base + i);
            end
            rd_en = 1'b0;
            chk(occ_bytes == 0, "R5 drained", occ_bytes, 0);
            rd_en = 1'b1; cyc(); rd_en = 1'b0;
            chk(rd_data == 24'(base + n - 1), "R8 hold last", rd_data, base + n - 1);
            chk(uflow == 1'(c), "R8 underflow flag", uflow, c);
            cyc();
            chk(uflow == 1'(c), "R8 sticky", uflow, c);
            flush_now();
            chk(uflow == 0, "R6 clr clears flag", uflow, 0);
         end
      end
      thr_custom_en = 1'b0; uflow_trig_en = 1'b0;

      // R5 format change mid-stream
      fmt = 2'd0; wr_en = 1'b1; wr_data = 24'h11; cyc(); wr_data = 24'h22; cyc();
      fmt = 2'd2; wr_data = 24'h33; cyc(); wr_en = 1'b0;
      chk(occ_bytes == 7, "R1 mixed occ", occ_bytes, 7);
      fmt = 2'd0;
      rd_en = 1'b1; cyc();
      chk(occ_bytes == 5, "R5 frees own slots", occ_bytes, 5);
      cyc();
      chk(occ_bytes == 3, "R5 frees own slots 2", occ_bytes, 3);
      cyc(); rd_en = 1'b0;
      chk(occ_bytes == 0, "R5 frees 24-bit slots", occ_bytes, 0);
      chk(rd_data == 24'h33, "R5 last value", rd_data, 24'h33);

      // simultaneous read and write
      fmt = 2'd2; wr_en = 1'b1; wr_data = 24'hA1; cyc();
      wr_data = 24'hA2; rd_en = 1'b1; cyc(); wr_en = 1'b0; rd_en = 1'b0;
      chk(occ_bytes == 3, "R5 rd+wr occ", occ_bytes, 3);
      chk(rd_data == 24'hA1, "R5 rd+wr data", rd_data, 24'hA1);

      // R6 clear beats write
      wr_en = 1'b1; wr_data = 24'hB0; clr = 1'b1; cyc(); clr = 1'b0; wr_en = 1'b0;
      chk(occ_bytes == 0, "R6 clr beats write", occ_bytes, 0);

      // R7 frame start
      uflow_trig_en = 1'b1; rd_en = 1'b1; cyc(); rd_en = 1'b0;
      chk(uflow == 1, "R8 flag set", uflow, 1);
      wr_en = 1'b1; wr_data = 24'hC0; cyc(); cyc(); wr_en = 1'b0;
      sof_clr_en = 1'b0; sof = 1'b1; cyc(); sof = 1'b0;
      chk(occ_bytes == 6, "R7 sof ignored", occ_bytes, 6);
      sof_clr_en = 1'b1; sof = 1'b1; cyc(); sof = 1'b0;
      chk(occ_bytes == 0, "R7 sof flush", occ_bytes, 0);
      chk(uflow == 1, "R7 flag kept", uflow, 1);
      flush_now();
      chk(uflow == 0, "R6 flag cleared", uflow, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule